// File: doc/BRIEF.md
# Fixed-cycle countdown timer

This block divides one of four externally generated tick strobes by a programmable 12-bit value. The selectable sources are 4096 Hz, 64 Hz, a once-per-second clock update and a once-per-minute clock update. Each selected tick lowers the count by one. The step from 1 to 0 is an event. On that same edge the count takes the preset again, so events repeat every preset periods without host help.

An event sets a sticky flag. If the interrupt enable is on, the event also pulls an active-low request line. For the two fast sources the line releases itself after a fixed number of clock cycles. For the clock-update sources it stays low until the host clears the flag or turns the interrupt enable off. Because the slow sources step only on the clock's own update strobes, their events line up with clock updates.

A small register port holds the preset, control and flag. The port also reads back the live count. All tick inputs are single-cycle strobes in the block's clock domain.

Top module: `cyc_timer`

## Requirements
- R1: After reset the count is 0, the flag is 0, `irq_n` is 1, and the preset and control registers read 0.
- R2: The write/read map is as follows. Address 0 is preset bits 7:0. Address 1 is preset bits 11:8 in data bits 3:0. Address 2 is control, with bit 0 enable, bits 2:1 source and bit 3 interrupt enable. Address 3 is the flag in bit 0. Addresses 4 and 5 read count bits 7:0 and 11:8.
- R3: Source code 00 selects `tick_4k`, 01 selects `tick_64`, 10 selects `tick_sec` and 11 selects `tick_min`. Strobes on the unselected inputs leave the count unchanged.
- R4: A control write that changes enable from 0 to 1 loads the count from the preset. A control write with enable 1 while already enabled does not reload.
- R5: A selected tick at count 1 is an event, and that edge reloads the preset. With preset N the events are N selected ticks apart.
- R6: A preset of 0 gives 4096 ticks between start and event.
- R7: While enable is 0 the count holds its value.
- R8: An event sets the flag, and it stays 1 until a write of 0 to flag bit 0. Writing 1 has no effect. An event in the same cycle as a clear leaves the flag at 1.
- R9: `irq_n` falls on the same edge as the flag only when interrupt enable is 1. With interrupt enable 0 the event sets the flag but `irq_n` stays 1.
- R10: For sources 00 and 01, `irq_n` stays low for exactly PULSE_CYC clock cycles after the event, then returns to 1.
- R11: For sources 10 and 11, `irq_n` stays low until the flag is cleared or interrupt enable is written 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| tick_4k | input | 1 | 4096 Hz strobe |
| tick_64 | input | 1 | 64 Hz strobe |
| tick_sec | input | 1 | Second-update strobe |
| tick_min | input | 1 | Minute-update strobe |
| tmr_flag | output | 1 | Sticky event flag |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A wrong count shows at the ports on the event tick. The flag rises one selected tick too early or too late, and the count read back at address 4 differs from the expected value after any tick. A wrong release state for the interrupt shows within PULSE_CYC cycles of an event on a fast source. On a slow source it shows on the first flag clear, where `irq_n` either fails to rise or rises too soon. A lost enable or source setting shows on the next strobe, because the count either moves when it should hold or holds when it should move.

// File: rtl/cyc_timer.sv
module cyc_timer #(
  parameter int CNT_W     = 12,
  parameter int PULSE_CYC = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       tick_4k,
  input  logic       tick_64,
  input  logic       tick_sec,
  input  logic       tick_min,
  output logic       tmr_flag,
  output logic       irq_n
);
  localparam int HI_W = CNT_W - 8;
  localparam int PW   = $clog2(PULSE_CYC + 1);

  logic [CNT_W-1:0] preset, cnt;
  logic [1:0]       src;
  logic             en, ie, flag;
  logic             irq_on, irq_lvl;
  logic [PW-1:0]    pulse;
  logic             sel_tick;

  always_comb begin
    case (src)
      2'd0:    sel_tick = tick_4k;
      2'd1:    sel_tick = tick_64;
      2'd2:    sel_tick = tick_sec;
      default: sel_tick = tick_min;
    endcase
  end

  wire wr_ctrl = wr_en && (wr_addr == 3'd2);
  wire wr_clr  = wr_en && (wr_addr == 3'd3) && !wr_data[0];
  wire start   = wr_ctrl && wr_data[0] && !en;
  wire step    = en && sel_tick && !start;
  wire evt     = step && (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preset <= '0;
      en     <= 1'b0;
      src    <= 2'd0;
      ie     <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        3'd0: preset[7:0]       <= wr_data;
        3'd1: preset[CNT_W-1:8] <= wr_data[HI_W-1:0];
        3'd2: begin
          en  <= wr_data[0];
          src <= wr_data[2:1];
          ie  <= wr_data[3];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (start) cnt <= preset;
    else if (step)  cnt <= evt ? preset : cnt - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag <= 1'b0;
    else if (evt)    flag <= 1'b1;
    else if (wr_clr) flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_on  <= 1'b0;
      irq_lvl <= 1'b0;
      pulse   <= '0;
    end else if (evt && ie) begin
      irq_on  <= 1'b1;
      irq_lvl <= src[1];
      pulse   <= PW'(PULSE_CYC - 1);
    end else if (irq_on) begin
      if (irq_lvl) begin
        if (wr_clr || (wr_ctrl && !wr_data[3])) irq_on <= 1'b0;
      end else if (pulse == '0) begin
        irq_on <= 1'b0;
      end else begin
        pulse <= pulse - PW'(1);
      end
    end
  end

  assign tmr_flag = flag;
  assign irq_n    = !irq_on;

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = preset[7:0];
      3'd1:    rd_data = {{(8-HI_W){1'b0}}, preset[CNT_W-1:8]};
      3'd2:    rd_data = {4'b0, ie, src, en};
      3'd3:    rd_data = {7'b0, flag};
      3'd4:    rd_data = cnt[7:0];
      3'd5:    rd_data = {{(8-HI_W){1'b0}}, cnt[CNT_W-1:8]};
      default: rd_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/cyc_timer_chk.sv
module cyc_timer_chk #(
  parameter int CNT_W     = 12,
  parameter int PULSE_CYC = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [2:0]       wr_addr,
  input logic             clr_bit,
  input logic             en,
  input logic             evt,
  input logic             lvl,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] preset,
  input logic             flag,
  input logic             irq_n
);
  localparam int RW = $clog2(PULSE_CYC + 2) + 1;
  logic [RW-1:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                low_run <= '0;
    else if (irq_n || evt)     low_run <= '0;
    else if (low_run != '1)    low_run <= low_run + RW'(1);
  end

  // R9
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> flag);

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !(wr_en && wr_addr == 3'd3 && !clr_bit) |=> flag);

  // R7
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !(wr_en && wr_addr == 3'd2) |=> $stable(cnt));

  // R5
  reload_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) && $stable(preset) |-> cnt == preset);

  // R10
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n && !lvl |-> low_run < RW'(PULSE_CYC));
endmodule

bind cyc_timer cyc_timer_chk #(.CNT_W(CNT_W), .PULSE_CYC(PULSE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .clr_bit(wr_data[0]), .en(en), .evt(evt), .lvl(irq_lvl),
  .cnt(cnt), .preset(preset), .flag(flag), .irq_n(irq_n)
);

// File: tb/cyc_timer_bench.sv
module cyc_timer_bench;
  localparam int P = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       tick_4k = 1'b0, tick_64 = 1'b0, tick_sec = 1'b0, tick_min = 1'b0;
  logic       tmr_flag, irq_n;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  cyc_timer #(.CNT_W(12), .PULSE_CYC(P)) u_cyc_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .tick_4k(tick_4k), .tick_64(tick_64), .tick_sec(tick_sec),
    .tick_min(tick_min), .tmr_flag(tmr_flag), .irq_n(irq_n)
  );

  // {src[1:0], preset[11:0]}
  localparam logic [13:0] VEC [4] = '{
    {2'd0, 12'd3}, {2'd1, 12'd5}, {2'd2, 12'd2}, {2'd3, 12'd4}
  };

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    rd_addr = a;
    #1 v = int'(rd_data);
  endtask

  task automatic rd_cnt(output int v);
    int lo, hi;
    rd(3'd4, lo);
    rd(3'd5, hi);
    v = hi * 256 + lo;
  endtask

  task automatic tick(input int s);
    @(negedge clk);
    case (s)
      0: tick_4k = 1'b1;
      1: tick_64 = 1'b1;
      2: tick_sec = 1'b1;
      default: tick_min = 1'b1;
    endcase
    @(negedge clk);
    tick_4k = 1'b0; tick_64 = 1'b0; tick_sec = 1'b0; tick_min = 1'b0;
  endtask

  task automatic setup(input int s, input int pre, input bit ien);
    wr(3'd2, 8'h00);
    wr(3'd3, 8'h00);
    wr(3'd0, 8'(pre));
    wr(3'd1, 8'(pre >> 8));
    wr(3'd2, {4'b0, ien, 2'(s), 1'b1});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got 0 expected 1 (run completed)");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq_n", int'(irq_n), 1);
    chk("R1 flag", int'(tmr_flag), 0);
    rd_cnt(v); chk("R1 count", v, 0);
    rd(3'd2, v); chk("R1 ctrl", v, 0);
    rd(3'd0, v); chk("R1 preset", v, 0);

    for (int i = 0; i < 4; i++) begin
      int s, n;
      s = int'(VEC[i][13:12]);
      n = int'(VEC[i][11:0]);
      setup(s, n, 1'b1);
      rd(3'd2, v); chk("R2 ctrl readback", v, 9 + 2 * s);
      rd_cnt(v); chk("R4 load on start", v, n);
      for (int k = 1; k < n; k++) begin
        tick((s + 1) % 4);
        tick(s);
      end
      rd_cnt(v); chk("R3 only selected source counts", v, 1);
      chk("R5 no early event", int'(tmr_flag), 0);
      tick(s);
      chk("R8 flag set", int'(tmr_flag), 1);
      chk("R9 irq low", int'(irq_n), 0);
      rd_cnt(v); chk("R5 reload", v, n);
      if (s < 2) begin
        repeat (P - 1) @(negedge clk);
        chk("R10 still low", int'(irq_n), 0);
        @(negedge clk);
        chk("R10 released", int'(irq_n), 1);
        chk("R8 flag sticky", int'(tmr_flag), 1);
      end else begin
        repeat (P + 3) @(negedge clk);
        chk("R11 held low", int'(irq_n), 0);
        wr(3'd3, 8'h00);
        chk("R11 release on clear", int'(irq_n), 1);
        chk("R8 flag cleared", int'(tmr_flag), 0);
      end
    end

    // R6 zero preset, with R9 ie off
    setup(0, 0, 1'b0);
    for (int k = 0; k < 4095; k++) tick(0);
    chk("R6 no event at 4095", int'(tmr_flag), 0);
    rd_cnt(v); chk("R6 count 1", v, 1);
    tick(0);
    chk("R6 event at 4096", int'(tmr_flag), 1);
    chk("R9 ie off keeps irq high", int'(irq_n), 1);

    // R8 write 1 ignored, write 0 clears
    wr(3'd3, 8'h01);
    chk("R8 write 1 ignored", int'(tmr_flag), 1);
    wr(3'd3, 8'h00);
    chk("R8 write 0 clears", int'(tmr_flag), 0);

    // R7 hold while disabled, R4 reload rules
    setup(1, 10, 1'b0);
    repeat (3) tick(1);
    rd_cnt(v); chk("R7 counting", v, 7);
    wr(3'd2, 8'h02);
    repeat (3) tick(1);
    rd_cnt(v); chk("R7 hold", v, 7);
    wr(3'd2, 8'h03);
    rd_cnt(v); chk("R4 reload on restart", v, 10);
    repeat (2) tick(1);
    wr(3'd2, 8'h03);
    rd_cnt(v); chk("R4 no reload when running", v, 8);

    // R5 repeat interval
    setup(0, 2, 1'b0);
    repeat (2) tick(0);
    chk("R5 first event", int'(tmr_flag), 1);
    wr(3'd3, 8'h00);
    tick(0);
    chk("R5 no event mid-interval", int'(tmr_flag), 0);
    tick(0);
    chk("R5 second event", int'(tmr_flag), 1);

    // R8 event wins over simultaneous clear
    setup(0, 1, 1'b0);
    @(negedge clk);
    tick_4k = 1'b1; wr_en = 1'b1; wr_addr = 3'd3; wr_data = 8'h00;
    @(negedge clk);
    tick_4k = 1'b0; wr_en = 1'b0;
    chk("R8 event beats clear", int'(tmr_flag), 1);

    // R11 release via interrupt-enable write
    setup(2, 1, 1'b1);
    tick(2);
    chk("R11 irq low", int'(irq_n), 0);
    wr(3'd2, 8'h05);
    chk("R11 release on ie off", int'(irq_n), 1);

    // R2 preset readback
    wr(3'd0, 8'hA5); wr(3'd1, 8'h0C);
    rd(3'd0, v); chk("R2 preset lo", v, 8'hA5);
    rd(3'd1, v); chk("R2 preset hi", v, 8'h0C);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule